// File: doc/BRIEF.md
# Flash partition command sequencer

This block takes a partition command for a flash region that emulates EEPROM. The command carries two sector counts, each in units of 256-byte sectors. One count is for direct data-flash use. The other is for EEPROM emulation backed by buffer RAM. At launch the block checks that the command is legal, meaning the command-word index is right and no load-data-field sequence is open. It then checks the two counts against the partition rules. An illegal command raises an access-error flag. A partition that breaks a rule raises a protection-violation flag. In both cases nothing is issued to the flash.

A command that passes every check runs a fixed sequence over a request/acknowledge interface. The first step is one erase of the whole data-flash block, including its nonvolatile information register. Three program steps follow, each writing one word of the information register: the data-flash count, the buffer-RAM count, and a duplicate of the buffer-RAM count. The command-complete flag drops when the command is accepted and rises again once the last step has been acknowledged. Running the command again repeats the whole sequence, so the earlier partition values are erased.

Top module: `flash_part_seq`

## Requirements
- R1: After synchronous reset, `done` is 1, `acc_err` and `prot_err` are 0, and `op_req` is 0.
- R2: If a launch is taken while `cmd_idx` is not binary 010, `acc_err` is set and no request is issued. Access errors take priority over partition checks, so `prot_err` stays 0.
- R3: If a launch is taken while `load_active` is 1, `acc_err` is set and no request is issued.
- R4: A buffer-RAM count above 16 sets `prot_err` and issues no request.
- R5: A data-flash count above 128 sets `prot_err` and issues no request.
- R6: When the buffer-RAM count is nonzero, `prot_err` is set if 128 minus the data-flash count is below 12.
- R7: When the buffer-RAM count is nonzero, `prot_err` is set if 128 minus the data-flash count is below 8 times the buffer-RAM count. This is the same test as an integer quotient below 8.
- R8: On a valid launch, `done` is 0 from the next cycle. The first request then has `op_kind`=1 (erase), `op_addr`=0 and `op_data`=0.
- R9: After the erase is acknowledged, three program requests follow in this order, each with `op_kind`=0:
  - address 0x0 with the data-flash count;
  - address 0x4 with the buffer-RAM count;
  - address 0x8 with the buffer-RAM count again.
- R10: A request stays asserted, with unchanged address and data, until `op_ack` is sampled high. Only then does the sequence move to the next step.
- R11: On the edge that samples the acknowledge of the last program step, `done` returns to 1 and `op_req` drops to 0. A repeated valid command runs the full sequence again, starting with the erase.
- R12: Both error flags hold their value until cleared by a 1 on `clr_acc_err` or `clr_prot_err`, respectively.
- R13: A launch is ignored while either error flag is set or while `done` is 0. An ignored launch issues no request and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Command launch pulse |
| cmd_idx | input | 3 | Command-word index at launch |
| load_active | input | 1 | A load-data-field sequence is open |
| df_cnt | input | CNT_W | Data-flash sector count |
| er_cnt | input | CNT_W | Buffer-RAM EEPROM sector count |
| clr_acc_err | input | 1 | Write-1 clear of the access-error flag |
| clr_prot_err | input | 1 | Write-1 clear of the protection-violation flag |
| op_ack | input | 1 | Acknowledge pulse for the current flash step |
| op_req | output | 1 | Flash step request |
| op_kind | output | 1 | 1 = erase, 0 = program word |
| op_addr | output | ADDR_W | Information-register offset of the step |
| op_data | output | DATA_W | Word to program (0 for erase) |
| done | output | 1 | Command-complete flag |
| acc_err | output | 1 | Access-error flag (sticky) |
| prot_err | output | 1 | Protection-violation flag (sticky) |

## Verification
The bound assertions check the following on every cycle:
- a pending request holds its address and data until it is acknowledged;
- no request is outstanding while `done` is high;
- `done` falls only after an accepted launch with both flags clear;
- either flag can rise only from a launch taken while `done` was high.

Other behaviour is only visible in the bench scenarios: the accept or reject decision across the full grid of data-flash counts 0 to 130 and buffer-RAM counts 0 to 18, the exact order and contents of the four steps, the priority of access errors over partition errors, and the ignoring of launches during a sequence.

// File: rtl/flash_part_pkg.sv
package flash_part_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG_DF,
    ST_PROG_ER,
    ST_PROG_DUP
  } seq_state_t;

  localparam logic OP_ERASE = 1'b1;
  localparam logic OP_PROG  = 1'b0;
endpackage

// File: rtl/part_rule_check.sv
module part_rule_check #(
  parameter int CNT_W        = 8,
  parameter int TOTAL_SECT   = 128,
  parameter int ER_MAX       = 16,
  parameter int MIN_EEE_SECT = 12,
  parameter int MIN_RATIO    = 8
) (
  input  logic [CNT_W-1:0] df_cnt,
  input  logic [CNT_W-1:0] er_cnt,
  output logic             rules_ok
);
  localparam int W = CNT_W + 6;

  logic [W-1:0] df_w, er_w, room, need;
  logic         df_fits, er_fits, eee_fits;

  always_comb begin
    df_w     = W'(df_cnt);
    er_w     = W'(er_cnt);
    room     = W'(TOTAL_SECT) - df_w;
    need     = er_w * W'(MIN_RATIO);
    df_fits  = df_w <= W'(TOTAL_SECT);
    er_fits  = er_w <= W'(ER_MAX);
    eee_fits = (er_w == '0) || ((room >= W'(MIN_EEE_SECT)) && (room >= need));
    rules_ok = df_fits && er_fits && eee_fits;
  end
endmodule

// File: rtl/part_op_seq.sv
module part_op_seq
  import flash_part_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int ERASE_ADDR = 0,
  parameter int INFO_BASE  = 0,
  parameter int WORD_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  df_cnt,
  input  logic [CNT_W-1:0]  er_cnt,
  input  logic              op_ack,
  output logic              op_req,
  output logic              op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              last_ack
);
  localparam logic [ADDR_W-1:0] A_ERASE = ADDR_W'(ERASE_ADDR);
  localparam logic [ADDR_W-1:0] A_DF    = ADDR_W'(INFO_BASE);
  localparam logic [ADDR_W-1:0] A_ER    = ADDR_W'(INFO_BASE + WORD_STEP);
  localparam logic [ADDR_W-1:0] A_DUP   = ADDR_W'(INFO_BASE + 2 * WORD_STEP);

  seq_state_t       state;
  logic [CNT_W-1:0] df_q, er_q;
  logic             step_done;

  assign step_done = op_req && op_ack;
  assign last_ack  = step_done && (state == ST_PROG_DUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_req  <= 1'b0;
      op_kind <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
      df_q    <= '0;
      er_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ERASE;
          op_req  <= 1'b1;
          op_kind <= OP_ERASE;
          op_addr <= A_ERASE;
          op_data <= '0;
          df_q    <= df_cnt;
          er_q    <= er_cnt;
        end
        ST_ERASE: if (step_done) begin
          state   <= ST_PROG_DF;
          op_kind <= OP_PROG;
          op_addr <= A_DF;
          op_data <= DATA_W'(df_q);
        end
        ST_PROG_DF: if (step_done) begin
          state   <= ST_PROG_ER;
          op_addr <= A_ER;
          op_data <= DATA_W'(er_q);
        end
        ST_PROG_ER: if (step_done) begin
          state   <= ST_PROG_DUP;
          op_addr <= A_DUP;
          op_data <= DATA_W'(er_q);
        end
        ST_PROG_DUP: if (step_done) begin
          state   <= ST_IDLE;
          op_req  <= 1'b0;
          op_data <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_part_seq.sv
module flash_part_seq #(
  parameter int CNT_W        = 8,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 8,
  parameter int TOTAL_SECT   = 128,
  parameter int ER_MAX       = 16,
  parameter int MIN_EEE_SECT = 12,
  parameter int MIN_RATIO    = 8,
  parameter int INFO_BASE    = 0,
  parameter int WORD_STEP    = 4,
  parameter logic [2:0] LEGAL_IDX = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [2:0]        cmd_idx,
  input  logic              load_active,
  input  logic [CNT_W-1:0]  df_cnt,
  input  logic [CNT_W-1:0]  er_cnt,
  input  logic              clr_acc_err,
  input  logic              clr_prot_err,
  input  logic              op_ack,
  output logic              op_req,
  output logic              op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              done,
  output logic              acc_err,
  output logic              prot_err
);
  logic rules_ok, last_ack;
  logic take, acc_bad, start;

  part_rule_check #(
    .CNT_W(CNT_W), .TOTAL_SECT(TOTAL_SECT), .ER_MAX(ER_MAX),
    .MIN_EEE_SECT(MIN_EEE_SECT), .MIN_RATIO(MIN_RATIO)
  ) u_rules (
    .df_cnt(df_cnt), .er_cnt(er_cnt), .rules_ok(rules_ok)
  );

  assign take    = launch && done && !acc_err && !prot_err;
  assign acc_bad = (cmd_idx != LEGAL_IDX) || load_active;
  assign start   = take && !acc_bad && rules_ok;

  part_op_seq #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERASE_ADDR(0),
    .INFO_BASE(INFO_BASE), .WORD_STEP(WORD_STEP)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .df_cnt(df_cnt), .er_cnt(er_cnt),
    .op_ack(op_ack), .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .last_ack(last_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b1;
      acc_err  <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      if (start)         done <= 1'b0;
      else if (last_ack) done <= 1'b1;

      if (take && acc_bad) acc_err <= 1'b1;
      else if (clr_acc_err) acc_err <= 1'b0;

      if (take && !acc_bad && !rules_ok) prot_err <= 1'b1;
      else if (clr_prot_err)             prot_err <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_part_seq_props.sv
module flash_part_seq_props #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              launch,
  input logic              op_req,
  input logic              op_ack,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic              done,
  input logic              acc_err,
  input logic              prot_err
);
  // R10: a pending request is held until acknowledged
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (op_req && !op_ack) |=> (op_req && $stable(op_addr) && $stable(op_data)));

  // R11: no request outstanding while complete
  assert_idle_when_done_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !op_req);

  // R13: done falls only after a launch taken with both flags clear
  assert_accept_gate_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ($past(launch) && !$past(acc_err) && !$past(prot_err)));

  // R2: access error rises only from a launch taken while complete
  assert_acc_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_err) |-> ($past(launch) && $past(done) && done && !op_req));

  // R4: protection violation rises only from a launch taken while complete
  assert_prot_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_err) |-> ($past(launch) && $past(done) && done && !op_req));

  // R11: completion follows an acknowledge
  assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(op_ack));
endmodule

bind flash_part_seq flash_part_seq_props #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_props (
  .clk(clk), .rst(rst), .launch(launch), .op_req(op_req), .op_ack(op_ack),
  .op_addr(op_addr), .op_data(op_data), .done(done), .acc_err(acc_err),
  .prot_err(prot_err)
);

// File: tb/flash_part_seq_bench.sv
module flash_part_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       launch = 1'b0;
  logic [2:0] cmd_idx = 3'b010;
  logic       load_active = 1'b0;
  logic [7:0] df_cnt = '0;
  logic [7:0] er_cnt = '0;
  logic       clr_acc_err = 1'b0;
  logic       clr_prot_err = 1'b0;
  logic       op_ack = 1'b0;
  logic       op_req, op_kind, done, acc_err, prot_err;
  logic [7:0] op_addr;
  logic [15:0] op_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  flash_part_seq u_flash_part_seq (
    .clk(clk), .rst(rst), .launch(launch), .cmd_idx(cmd_idx),
    .load_active(load_active), .df_cnt(df_cnt), .er_cnt(er_cnt),
    .clr_acc_err(clr_acc_err), .clr_prot_err(clr_prot_err), .op_ack(op_ack),
    .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .done(done), .acc_err(acc_err), .prot_err(prot_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic fire(input int idx, input bit ld, input int df, input int er);
    cmd_idx = 3'(idx); load_active = ld; df_cnt = 8'(df); er_cnt = 8'(er);
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0; load_active = 1'b0; cmd_idx = 3'b010;
  endtask

  task automatic clear_flags();
    clr_acc_err = 1'b1; clr_prot_err = 1'b1;
    @(negedge clk);
    clr_acc_err = 1'b0; clr_prot_err = 1'b0;
    chk("R12 flags cleared", int'(acc_err) + int'(prot_err), 0);
  endtask

  task automatic run_valid(input int df, input int er, input bit hold, input bit poke);
    fire(2, 0, df, er);
    chk("R8 done low after launch", int'(done), 0);
    for (int s = 0; s < 4; s++) begin
      chk("R8/R9 request present", int'(op_req), 1);
      chk("R8/R9 kind", int'(op_kind), (s == 0) ? 1 : 0);
      chk("R8/R9 addr", int'(op_addr), (s == 0) ? 0 : (s - 1) * 4);
      chk("R8/R9 data", int'(op_data), (s == 0) ? 0 : ((s == 1) ? df : er));
      if (hold && s == 0) begin
        @(negedge clk);
        @(negedge clk);
        chk("R10 request held", int'(op_req), 1);
        chk("R10 kind held", int'(op_kind), 1);
      end
      if (poke && s == 1) begin
        fire(0, 0, 200, 30);
        chk("R13 busy launch no acc_err", int'(acc_err), 0);
        chk("R13 busy launch no prot_err", int'(prot_err), 0);
        chk("R13 busy step unchanged", int'(op_addr), 0);
      end
      op_ack = 1'b1;
      @(negedge clk);
      op_ack = 1'b0;
    end
    chk("R11 done after last ack", int'(done), 1);
    chk("R11 request dropped", int'(op_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 done", int'(done), 1);
    chk("R1 acc_err", int'(acc_err), 0);
    chk("R1 prot_err", int'(prot_err), 0);
    chk("R1 op_req", int'(op_req), 0);

    // R2: every wrong index, with legal and with illegal counts
    for (int i = 0; i < 8; i++) begin
      if (i != 2) begin
        fire(i, 0, 64, (i == 5) ? 20 : 4);
        chk("R2 acc_err set", int'(acc_err), 1);
        chk("R2 prot_err clear", int'(prot_err), 0);
        chk("R2 no request", int'(op_req), 0);
        chk("R2 done kept", int'(done), 1);
        clear_flags();
      end
    end

    // R3 and R12 stickiness, R13 launch while flagged
    fire(2, 1, 64, 4);
    chk("R3 acc_err set", int'(acc_err), 1);
    chk("R3 no request", int'(op_req), 0);
    repeat (5) @(negedge clk);
    chk("R12 acc_err sticky", int'(acc_err), 1);
    fire(2, 0, 64, 4);
    chk("R13 flagged launch no request", int'(op_req), 0);
    chk("R13 flagged launch done", int'(done), 1);
    chk("R13 flagged launch prot", int'(prot_err), 0);
    clr_prot_err = 1'b1;
    @(negedge clk);
    clr_prot_err = 1'b0;
    chk("R12 other clear ignored", int'(acc_err), 1);
    clear_flags();

    // R10, R13 while busy, R11 repeat
    run_valid(100, 2, 1, 1);
    run_valid(100, 2, 0, 0);

    // R4..R9 sweep
    for (int df = 0; df <= 130; df++) begin
      for (int er = 0; er <= 18; er++) begin
        bit ok;
        string why;
        ok = 1;
        why = "";
        if (er > 16) begin ok = 0; why = "R4"; end
        else if (df > 128) begin ok = 0; why = "R5"; end
        else if (er != 0 && (128 - df) < 12) begin ok = 0; why = "R6"; end
        else if (er != 0 && ((128 - df) / er) < 8) begin ok = 0; why = "R7"; end
        if (ok) begin
          run_valid(df, er, 0, 0);
        end else begin
          fire(2, 0, df, er);
          chk({why, " prot_err set"}, int'(prot_err), 1);
          chk({why, " acc_err clear"}, int'(acc_err), 0);
          chk({why, " no request"}, int'(op_req), 0);
          chk({why, " done kept"}, int'(done), 1);
          clear_flags();
        end
      end
    end

    finish_run();
  end
endmodule